// File: doc/BRIEF.md
# Rectangle Fill Engine

This block paints a solid rectangle into a frame memory that holds one 16-bit RGB565 colour per pixel. Software, or an upstream command queue, stages the fill through 32-bit command words. Each word carries an opcode in its top byte and a payload below it. Separate words set the destination byte address, the horizontal and vertical extents (each stored as size minus one) and the colour. A final start word launches the fill.

While it runs, the engine walks the rectangle one row at a time, left to right, and issues one write request per pixel on a valid/ready memory port. It moves 2 bytes per pixel. At the end of each row it jumps to the start of the previous row plus the line pitch. When the last write is accepted it drops busy. Depending on the option bits of the start word, it also sets a sticky done flag, pulses an interrupt, or both. Commands are accepted only while the engine is idle.

Top module: `rfill_engine`

## Requirements
- R1: A command word is accepted in any cycle with `cmd_valid` high while the engine is idle; `cmd_ready` equals not-busy. The opcode is `cmd_data[31:24]`.
- R2: Opcode 0x0C loads the destination byte address from `cmd_data[23:0]`, with bit 0 forced to 0. All write addresses are even.
- R3: Opcode 0x0E loads the width minus one from `cmd_data[9:0]`. Opcode 0x0F loads the height minus one from `cmd_data[9:0]`. Payload bits above bit 9 are ignored.
- R4: Opcode 0x0B loads the RGB565 colour from `cmd_data[15:0]`. Every write of the fill carries that colour on `mem_data`.
- R5: Opcode 0x23 starts the fill. In the next cycle `busy` and `mem_valid` are high and `mem_addr` holds the destination address.
- R6: Writes go in row-major order with exactly (W+1)*(H+1) accepted writes. The address steps by 2 within a row. Each new row starts at the previous row's start plus `row_pitch`, with bit 0 of the pitch ignored. The pitch is sampled when the fill starts, and addresses wrap modulo 2^24.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R8: `busy` stays high from the cycle after the start word until the cycle after the last write is accepted. `busy` and `mem_valid` are then low together.
- R9: If bit 0 of the start payload is set, `done` rises in the cycle after the last accepted write and stays high. Any accepted start word clears it. Without bit 0, `done` stays low.
- R10: If bit 1 of the start payload is set, `irq` is high for exactly one cycle, the cycle after the last accepted write.
- R11: Bit 2 of the start payload has no effect: the write sequence is the same as a plain fill.
- R12: Words with any other opcode are dropped and leave the staged address, sizes and colour unchanged.
- R13: Synchronous reset clears `busy`, `mem_valid`, `done` and `irq`, and sets the staged address, sizes and colour to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_data | input | 32 | Command word, opcode in top byte |
| cmd_ready | output | 1 | Engine idle and accepting commands |
| row_pitch | input | 24 | Line pitch in bytes, sampled at start |
| mem_valid | output | 1 | Pixel write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 24 | Byte address of the pixel |
| mem_data | output | 16 | Pixel colour |
| busy | output | 1 | Fill in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The first fill after reset uses the all-zero staged values and must write one black pixel at address 0. A multi-row fill with an odd start address and a free-running memory checks the bit-0 masking and the row jump by the pitch. A tall one-pixel-wide fill under pseudo-random back-pressure tells the column-end path apart from the row-end path and checks the hold behaviour. A fill that starts near the top of the address space checks the wrap. Unknown opcodes and the raster-operation bit are sent before a repeated fill, which must reproduce the earlier address stream exactly.

// File: rtl/rfill_pkg.sv
package rfill_pkg;
  localparam logic [7:0] OP_DST_ADDR = 8'h0C;
  localparam logic [7:0] OP_H_LAST   = 8'h0E;
  localparam logic [7:0] OP_V_LAST   = 8'h0F;
  localparam logic [7:0] OP_COLOUR   = 8'h0B;
  localparam logic [7:0] OP_START    = 8'h23;

  typedef struct packed {
    logic rop_req;   // accepted and ignored
    logic irq_req;
    logic flag_req;
  } start_opts_t;
endpackage

// File: rtl/rfill_cmd_regs.sv
module rfill_cmd_regs
  import rfill_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 10,
  parameter int COL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  h_last,
  output logic [CNT_W-1:0]  v_last,
  output logic [COL_W-1:0]  colour,
  output logic              start,
  output start_opts_t       opts
);
  localparam int OP_LSB = CMD_W - 8;

  logic [7:0] opcode;
  logic       known;

  assign opcode = cmd_data[CMD_W-1:OP_LSB];
  assign start  = accept && (opcode == OP_START);
  assign opts   = start_opts_t'(cmd_data[2:0]);
  assign known  = (opcode == OP_DST_ADDR) || (opcode == OP_H_LAST) ||
                  (opcode == OP_V_LAST) || (opcode == OP_COLOUR) ||
                  (opcode == OP_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_addr <= '0;
      h_last   <= '0;
      v_last   <= '0;
      colour   <= '0;
    end else if (accept) begin
      case (opcode)
        OP_DST_ADDR: dst_addr <= {cmd_data[ADDR_W-1:1], 1'b0};
        OP_H_LAST:   h_last   <= cmd_data[CNT_W-1:0];
        OP_V_LAST:   v_last   <= cmd_data[CNT_W-1:0];
        OP_COLOUR:   colour   <= cmd_data[COL_W-1:0];
        default: ;
      endcase
    end
  end

  // R12: an unknown opcode leaves every staged value untouched
  assert_ignore_R12: assert property (@(posedge clk) disable iff (rst)
    accept && !known |=> $stable(dst_addr) && $stable(h_last) &&
                         $stable(v_last) && $stable(colour));
endmodule

// File: rtl/rfill_walker.sv
module rfill_walker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 10,
  parameter int COL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  h_last,
  input  logic [CNT_W-1:0]  v_last,
  input  logic [COL_W-1:0]  colour,
  input  logic [ADDR_W-1:0] row_pitch,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [COL_W-1:0]  mem_data,
  output logic              finish
);
  localparam logic [ADDR_W-1:0] PIX_BYTES = ADDR_W'(2);

  logic [CNT_W-1:0]  x_cnt, y_cnt, x_end, y_end;
  logic [ADDR_W-1:0] row_base, pitch;
  logic              beat, row_end, last;

  assign beat    = mem_valid && mem_ready;
  assign row_end = (x_cnt == x_end);
  assign last    = row_end && (y_cnt == y_end);
  assign finish  = beat && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      row_base  <= '0;
      pitch     <= '0;
      x_cnt     <= '0;
      y_cnt     <= '0;
      x_end     <= '0;
      y_end     <= '0;
    end else if (start && !mem_valid) begin
      mem_valid <= 1'b1;
      mem_addr  <= dst_addr;
      row_base  <= dst_addr;
      mem_data  <= colour;
      pitch     <= {row_pitch[ADDR_W-1:1], 1'b0};
      x_cnt     <= '0;
      y_cnt     <= '0;
      x_end     <= h_last;
      y_end     <= v_last;
    end else if (beat) begin
      if (last) begin
        mem_valid <= 1'b0;
      end else if (row_end) begin
        x_cnt    <= '0;
        y_cnt    <= y_cnt + 1'b1;
        row_base <= row_base + pitch;
        mem_addr <= row_base + pitch;
      end else begin
        x_cnt    <= x_cnt + 1'b1;
        mem_addr <= mem_addr + PIX_BYTES;
      end
    end
  end

  // R7: a stalled request holds still
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R6: inside a row the next pixel is two bytes on
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    beat && !row_end |=> mem_valid && (mem_addr == $past(mem_addr) + PIX_BYTES));
  // R2: write addresses stay even
  assert_even_R2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !mem_addr[0]);
endmodule

// File: rtl/rfill_status.sv
module rfill_status
  import rfill_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  start_opts_t opts,
  input  logic        finish,
  output logic        done,
  output logic        irq
);
  start_opts_t held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= finish && held.irq_req;
      if (start) begin
        held <= opts;
        done <= 1'b0;
      end else if (finish && held.flag_req) begin
        done <= 1'b1;
      end
    end
  end

  // R10: the interrupt lasts a single cycle
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R9: an accepted start clears the completion flag
  assert_done_clear_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);
endmodule

// File: rtl/rfill_engine.sv
module rfill_engine
  import rfill_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 10,
  parameter int COL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] row_pitch,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [COL_W-1:0]  mem_data,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic [ADDR_W-1:0] dst_addr;
  logic [CNT_W-1:0]  h_last, v_last;
  logic [COL_W-1:0]  colour;
  logic              accept, start, finish;
  start_opts_t       opts;

  assign busy      = mem_valid;
  assign cmd_ready = !mem_valid;
  assign accept    = cmd_valid && cmd_ready;

  rfill_cmd_regs #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .COL_W(COL_W)) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .cmd_data(cmd_data),
    .dst_addr(dst_addr), .h_last(h_last), .v_last(v_last), .colour(colour),
    .start(start), .opts(opts)
  );

  rfill_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .COL_W(COL_W)) u_walk (
    .clk(clk), .rst(rst), .start(start), .dst_addr(dst_addr),
    .h_last(h_last), .v_last(v_last), .colour(colour), .row_pitch(row_pitch),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .finish(finish)
  );

  rfill_status u_stat (
    .clk(clk), .rst(rst), .start(start), .opts(opts), .finish(finish),
    .done(done), .irq(irq)
  );

  // R5: a start brings up the request at the staged address
  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && mem_valid && (mem_addr == $past(dst_addr)));
  // R8: no command is taken during a fill
  assert_no_cmd_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);
endmodule

// File: tb/rfill_engine_tb.sv
module rfill_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready;
  logic [23:0] row_pitch = '0;
  logic        mem_valid, mem_ready = 1'b1;
  logic [23:0] mem_addr;
  logic [15:0] mem_data;
  logic        busy, done, irq;

  always #10 clk = ~clk;

  rfill_engine u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .row_pitch(row_pitch), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .done(done), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // back-pressure generator
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #2;
    mem_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // behavioural reference model
  int unsigned q[$];
  bit m_busy, m_done, m_irq, f_done, f_irq;
  int unsigned p_addr, p_w, p_h, p_col, m_col;

  always @(negedge clk) begin
    if (rst) begin
      q.delete();
      m_busy = 0; m_done = 0; m_irq = 0; f_done = 0; f_irq = 0;
      p_addr = 0; p_w = 0; p_h = 0; p_col = 0; m_col = 0;
    end else begin
      bit nb, nd, ni;
      chk(busy == m_busy, "R8 busy", busy, m_busy);
      chk(mem_valid == m_busy, "R5 mem_valid", mem_valid, m_busy);
      chk(cmd_ready == !m_busy, "R1 cmd_ready", cmd_ready, !m_busy);
      chk(done == m_done, "R9 done", done, m_done);
      chk(irq == m_irq, "R10 irq", irq, m_irq);
      if (m_busy && q.size() > 0) begin
        chk(mem_addr == q[0][23:0], "R6 R7 mem_addr", mem_addr, q[0]);
        chk(mem_data == m_col[15:0], "R4 mem_data", mem_data, m_col);
      end
      nb = m_busy; nd = m_done; ni = 0;
      if (m_busy && mem_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          nb = 0; ni = f_irq;
          if (f_done) nd = 1;
        end
      end
      if (!m_busy && cmd_valid) begin
        case (cmd_data[31:24])
          8'h0C: p_addr = cmd_data[23:0] & 24'hFFFFFE;
          8'h0E: p_w = cmd_data[9:0];
          8'h0F: p_h = cmd_data[9:0];
          8'h0B: p_col = cmd_data[15:0];
          8'h23: begin
            // bit 2 (R11) deliberately has no effect on the stream
            for (int y = 0; y <= int'(p_h); y++)
              for (int x = 0; x <= int'(p_w); x++)
                q.push_back((p_addr + y * (row_pitch & 24'hFFFFFE) + 2 * x) & 24'hFFFFFF);
            m_col = p_col; f_done = cmd_data[0]; f_irq = cmd_data[1];
            nb = 1; nd = 0;
          end
          default: ; // R12 unknown opcode dropped
        endcase
      end
      m_busy = nb; m_done = nd; m_irq = ni;
    end
  end

  task automatic send(input logic [31:0] w);
    cmd_valid = 1'b1;
    cmd_data  = w;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk); @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(!busy, "R8 fill ends", busy, 0);
    repeat (2) @(posedge clk); #2;
  endtask

  task automatic fill(input int unsigned a, input int unsigned w1, input int unsigned h1,
                      input int unsigned c, input logic [31:0] go);
    send(32'h0C00_0000 | a);
    send(32'h0E00_0000 | w1);
    send(32'h0F00_0000 | h1);
    send(32'h0B00_0000 | c);
    send(go);
    wait_idle();
  endtask

  int unsigned seen_a[$], seen_b[$];
  bit rec_a = 0, rec_b = 0;
  always @(negedge clk) begin
    if (mem_valid && mem_ready) begin
      if (rec_a) seen_a.push_back(mem_addr);
      if (rec_b) seen_b.push_back(mem_addr);
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst = 1'b0;
    repeat (2) @(posedge clk); #2;
    // R13: go with reset values -> one black pixel at address 0, flags set
    send(32'h2300_0003);
    wait_idle();
    chk(done == 1'b1, "R9 done sticky", done, 1);
    // R2 R3 R6: odd address masked, 4x3 with pitch 640, free-running memory
    row_pitch = 24'd640;
    fill(32'h0012_3457, 3, 2, 16'hF800, 32'h2300_0001);
    chk(done == 1'b1, "R9 done after fill", done, 1);
    // R7 R10: one column, five rows, back-pressure, irq only
    rdy_mode = 1;
    row_pitch = 24'd321;  // odd pitch: bit 0 ignored (R6)
    fill(24'h000400, 0, 4, 16'h07E0, 32'h2300_0002);
    chk(done == 1'b0, "R9 done stays low without bit 0", done, 0);
    // reference stream for R11/R12 comparison
    rec_a = 1;
    fill(24'h001000, 2, 1, 16'h001F, 32'h2300_0000);
    rec_a = 0;
    // R12 unknown opcodes, then R11 go with raster bit set
    send(32'h0D00_0FF0); send(32'h0100_0005); send(32'hFF12_3456); send(32'h1700_FFFF);
    rec_b = 1;
    send(32'h2300_0004);
    wait_idle();
    rec_b = 0;
    chk(seen_a.size() == seen_b.size(), "R11 R12 write count", seen_b.size(), seen_a.size());
    for (int i = 0; i < seen_a.size() && i < seen_b.size(); i++)
      chk(seen_a[i] == seen_b[i], "R11 R12 same stream", seen_b[i], seen_a[i]);
    // R3 upper payload bits ignored; R6 address wrap
    rdy_mode = 0;
    row_pitch = 24'd16;
    fill(24'hFFFFFC, 32'h00FC04, 32'h00F801, 16'h1234, 32'h2300_0003);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule